// File: doc/BRIEF.md
# Configuration Access Request Sequencer

This block lets software reach the configuration space of devices below a PCIe root port through a few registers. Software first loads a target word that holds the bus, device, function and dword register number. It then sets the send-enable bit in the control register, together with the bit that picks a type 0 or a type 1 request. An access to the data register then becomes one configuration request. A read of the data register becomes a configuration read. A write to the data register becomes a configuration write that carries the written word.

The request leaves on a valid/ready port. A completion returns on a single-cycle response port with a data word and an unsupported-request flag. While a request is outstanding the block raises a busy status and turns away every register access. A read result is returned when its completion arrives. An unsupported-request completion returns all ones and sets a sticky error bit. Software clears that bit by writing a one to it before the next access. Writing zero to the control register ends the access window. After that the data register is plain local storage and no requests go out.

Top module: `cfgacc`

## Requirements
- R1: After reset the target, control, data and error registers read as zero, `sw_busy` is low and `req_valid` is low.
- R2: The target register (select 0) keeps bus in bits 31:24, device in bits 23:19, function in bits 18:16 and the dword register number in bits 11:2. Bits 15:12 and 1:0 are ignored and read as zero. A request carries exactly these fields, whatever was written to bits 1:0.
- R3: The control register (select 1) keeps only bit 31 (send enable) and bit 8 (1 = type 1 request, 0 = type 0). All other bits read as zero.
- R4: With send enable set, an accepted read of the data register (select 2) issues a read request (`req_write`=0, `req_type1` = control bit 8). `sw_busy` is high from the next cycle. `sw_rvalid` pulses with the completion data one cycle after the completion cycle, and `sw_busy` is low in that same cycle.
- R5: With send enable set, an accepted write of the data register issues a write request (`req_write`=1) that carries the written word. `sw_busy` stays high until the cycle after the completion.
- R6: While `req_valid` is high and `req_ready` is low, the request and all its fields stay unchanged.
- R7: An unsupported-request completion sets bit 4 of the error register (select 3). For a read, the returned word and the data register are 32'hFFFF_FFFF.
- R8: Writing the error register clears bit 4 only when bit 4 of the written word is 1. Writing a word with bit 4 at 0 leaves the error register unchanged.
- R9: With send enable clear, data register accesses read and write local storage and issue no request. Writing zero to the control register clears send enable.
- R10: While `sw_busy` is high, register reads and writes are ignored: no register changes and no `sw_rvalid` is returned.
- R11: An accepted register read that issues no request returns `sw_rvalid` with the register value in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_en | input | 1 | Register access strobe |
| sw_we | input | 1 | 1 = register write, 0 = register read |
| sw_sel | input | 2 | Register select: 0 target, 1 control, 2 data, 3 error |
| sw_wdata | input | 32 | Register write data |
| sw_rdata | output | 32 | Register read data |
| sw_rvalid | output | 1 | Read data valid pulse |
| sw_busy | output | 1 | A configuration access is outstanding |
| req_valid | output | 1 | Configuration request valid |
| req_ready | input | 1 | Completer accepts the request |
| req_write | output | 1 | 1 = configuration write |
| req_type1 | output | 1 | 1 = type 1, 0 = type 0 |
| req_bus | output | 8 | Target bus number |
| req_dev | output | 5 | Target device number |
| req_fn | output | 3 | Target function number |
| req_reg | output | 10 | Target dword register number |
| req_wdata | output | 32 | Write data of the request |
| cpl_valid | input | 1 | Completion strobe |
| cpl_ur | input | 1 | Completion reports unsupported request |
| cpl_data | input | 32 | Completion data |

## Verification
A plain register read has its result due one cycle after the edge that accepts it. A data access that issues a request raises `sw_busy` one cycle after it is accepted. Its result, the falling `sw_busy` and any error bit are all due one cycle after the edge that samples `cpl_valid`. The bench drives every input at a falling edge and reads the outputs at the next falling edge. For requests, it waits on `sw_rvalid` or a low `sw_busy` in a bounded loop. The bench sweeps both request types, devices with and without unsupported-request completions, and several accept and completion delays, so the result is checked at every latency.

// File: rtl/cfgacc_pkg.sv
package cfgacc_pkg;

  localparam int unsigned CFG_DW = 32;

  // control and error bit positions decoded by software
  localparam int unsigned EN_BIT   = 31;
  localparam int unsigned TYPE_BIT = 8;
  localparam int unsigned UR_BIT   = 4;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_DATA = 2'd2,
    SEL_ERR  = 2'd3
  } sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } seq_st_e;

endpackage

// File: rtl/cfgacc_regs.sv
module cfgacc_regs
  import cfgacc_pkg::*;
#(
  parameter int unsigned BUS_W = 8,
  parameter int unsigned DEV_W = 5,
  parameter int unsigned FN_W  = 3,
  parameter int unsigned REG_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  sel_e              sel,
  input  logic [CFG_DW-1:0] wdata,
  input  logic              fin,
  input  logic              fin_rd,
  input  logic              fin_ur,
  input  logic [CFG_DW-1:0] fin_data,
  output logic [CFG_DW-1:0] addr_q,
  output logic              ctrl_en,
  output logic              ctrl_t1,
  output logic              err_ur,
  output logic [CFG_DW-1:0] rd_word
);

  localparam int unsigned FN_LSB  = CFG_DW - BUS_W - DEV_W - FN_W;
  localparam int unsigned REG_MSB = REG_W + 1;

  // bits of the target word that are stored; the rest read as zero
  logic [CFG_DW-1:0] keep_mask;

  genvar gb;
  generate
    for (gb = 0; gb < CFG_DW; gb++) begin : g_mask
      if (gb >= FN_LSB || (gb >= 2 && gb <= REG_MSB)) begin : g_keep
        assign keep_mask[gb] = 1'b1;
      end else begin : g_drop
        assign keep_mask[gb] = 1'b0;
      end
    end
  endgenerate

  logic [CFG_DW-1:0] addr_r;
  logic [CFG_DW-1:0] data_r;
  logic              en_r;
  logic              t1_r;
  logic              ur_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_r <= '0;
      data_r <= '0;
      en_r   <= 1'b0;
      t1_r   <= 1'b0;
      ur_r   <= 1'b0;
    end else begin
      if (wr_en) begin
        unique case (sel)
          SEL_ADDR: addr_r <= wdata & keep_mask;
          SEL_CTRL: begin
            en_r <= wdata[EN_BIT];
            t1_r <= wdata[TYPE_BIT];
          end
          SEL_DATA: data_r <= wdata;
          SEL_ERR:  if (wdata[UR_BIT]) ur_r <= 1'b0;
          default:  ;
        endcase
      end
      // completion results; register writes are blocked while one is pending
      if (fin_rd) data_r <= fin_data;
      if (fin && fin_ur) ur_r <= 1'b1;
    end
  end

  always_comb begin
    rd_word = '0;
    unique case (sel)
      SEL_ADDR: rd_word = addr_r;
      SEL_CTRL: begin
        rd_word[EN_BIT]   = en_r;
        rd_word[TYPE_BIT] = t1_r;
      end
      SEL_DATA: rd_word = data_r;
      SEL_ERR:  rd_word[UR_BIT] = ur_r;
      default:  rd_word = '0;
    endcase
  end

  assign addr_q  = addr_r;
  assign ctrl_en = en_r;
  assign ctrl_t1 = t1_r;
  assign err_ur  = ur_r;

endmodule

// File: rtl/cfgacc_seq.sv
module cfgacc_seq
  import cfgacc_pkg::*;
#(
  parameter int unsigned BUS_W = 8,
  parameter int unsigned DEV_W = 5,
  parameter int unsigned FN_W  = 3,
  parameter int unsigned REG_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_wr,
  input  logic              start_t1,
  input  logic [CFG_DW-1:0] addr_word,
  input  logic [CFG_DW-1:0] wdata,
  input  logic              req_ready,
  input  logic              cpl_valid,
  input  logic              cpl_ur,
  input  logic [CFG_DW-1:0] cpl_data,
  output logic              busy,
  output logic              req_valid,
  output logic              req_write,
  output logic              req_type1,
  output logic [BUS_W-1:0]  req_bus,
  output logic [DEV_W-1:0]  req_dev,
  output logic [FN_W-1:0]   req_fn,
  output logic [REG_W-1:0]  req_reg,
  output logic [CFG_DW-1:0] req_wdata,
  output logic              fin,
  output logic              fin_rd,
  output logic              fin_ur,
  output logic [CFG_DW-1:0] fin_data
);

  localparam int unsigned BUS_LSB = CFG_DW - BUS_W;
  localparam int unsigned DEV_LSB = BUS_LSB - DEV_W;
  localparam int unsigned FN_LSB  = DEV_LSB - FN_W;

  seq_st_e           st_q;
  logic              wr_q;
  logic              t1_q;
  logic [BUS_W-1:0]  bus_q;
  logic [DEV_W-1:0]  dev_q;
  logic [FN_W-1:0]   fn_q;
  logic [REG_W-1:0]  reg_q;
  logic [CFG_DW-1:0] wd_q;

  // the two byte-select bits and the gap above the register number are
  // never part of a request
  logic unused_addr;
  assign unused_addr = ^{addr_word[1:0], addr_word[FN_LSB-1:REG_W+2]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      wr_q  <= 1'b0;
      t1_q  <= 1'b0;
      bus_q <= '0;
      dev_q <= '0;
      fn_q  <= '0;
      reg_q <= '0;
      wd_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            wr_q  <= start_wr;
            t1_q  <= start_t1;
            bus_q <= addr_word[BUS_LSB +: BUS_W];
            dev_q <= addr_word[DEV_LSB +: DEV_W];
            fn_q  <= addr_word[FN_LSB +: FN_W];
            reg_q <= addr_word[2 +: REG_W];
            wd_q  <= wdata;
            st_q  <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (req_ready) st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (cpl_valid) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign req_valid = (st_q == ST_REQ);
  assign req_write = wr_q;
  assign req_type1 = t1_q;
  assign req_bus   = bus_q;
  assign req_dev   = dev_q;
  assign req_fn    = fn_q;
  assign req_reg   = reg_q;
  assign req_wdata = wd_q;

  // completion is only taken once the request has been accepted
  assign fin      = (st_q == ST_WAIT) && cpl_valid;
  assign fin_rd   = fin && !wr_q;
  assign fin_ur   = fin && cpl_ur;
  assign fin_data = cpl_ur ? {CFG_DW{1'b1}} : cpl_data;

endmodule

// File: rtl/cfgacc_rdport.sv
module cfgacc_rdport
  import cfgacc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_acc,
  input  logic [CFG_DW-1:0] rd_word,
  input  logic              fin_rd,
  input  logic [CFG_DW-1:0] fin_data,
  output logic              rvalid,
  output logic [CFG_DW-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= fin_rd || rd_acc;
      if (fin_rd) begin
        rdata <= fin_data;
      end else if (rd_acc) begin
        rdata <= rd_word;
      end
    end
  end

endmodule

// File: rtl/cfgacc.sv
module cfgacc
  import cfgacc_pkg::*;
#(
  parameter int unsigned BUS_W = 8,
  parameter int unsigned DEV_W = 5,
  parameter int unsigned FN_W  = 3,
  parameter int unsigned REG_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_en,
  input  logic              sw_we,
  input  logic [1:0]        sw_sel,
  input  logic [CFG_DW-1:0] sw_wdata,
  output logic [CFG_DW-1:0] sw_rdata,
  output logic              sw_rvalid,
  output logic              sw_busy,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic              req_type1,
  output logic [BUS_W-1:0]  req_bus,
  output logic [DEV_W-1:0]  req_dev,
  output logic [FN_W-1:0]   req_fn,
  output logic [REG_W-1:0]  req_reg,
  output logic [CFG_DW-1:0] req_wdata,
  input  logic              cpl_valid,
  input  logic              cpl_ur,
  input  logic [CFG_DW-1:0] cpl_data
);

  sel_e              sel;
  logic              acc;
  logic              launch;
  logic              rd_acc;
  logic [CFG_DW-1:0] addr_q;
  logic              ctrl_en;
  logic              ctrl_t1;
  logic              err_ur;
  logic [CFG_DW-1:0] rd_word;
  logic              fin;
  logic              fin_rd;
  logic              fin_ur;
  logic [CFG_DW-1:0] fin_data;

  assign sel    = sel_e'(sw_sel);
  // accesses are turned away while a request is outstanding
  assign acc    = sw_en && !sw_busy;
  assign launch = acc && ctrl_en && (sel == SEL_DATA);
  assign rd_acc = acc && !sw_we && !launch;

  cfgacc_regs #(
    .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .REG_W(REG_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (acc && sw_we),
    .sel      (sel),
    .wdata    (sw_wdata),
    .fin      (fin),
    .fin_rd   (fin_rd),
    .fin_ur   (fin_ur),
    .fin_data (fin_data),
    .addr_q   (addr_q),
    .ctrl_en  (ctrl_en),
    .ctrl_t1  (ctrl_t1),
    .err_ur   (err_ur),
    .rd_word  (rd_word)
  );

  cfgacc_seq #(
    .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .REG_W(REG_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (launch),
    .start_wr  (sw_we),
    .start_t1  (ctrl_t1),
    .addr_word (addr_q),
    .wdata     (sw_wdata),
    .req_ready (req_ready),
    .cpl_valid (cpl_valid),
    .cpl_ur    (cpl_ur),
    .cpl_data  (cpl_data),
    .busy      (sw_busy),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_type1 (req_type1),
    .req_bus   (req_bus),
    .req_dev   (req_dev),
    .req_fn    (req_fn),
    .req_reg   (req_reg),
    .req_wdata (req_wdata),
    .fin       (fin),
    .fin_rd    (fin_rd),
    .fin_ur    (fin_ur),
    .fin_data  (fin_data)
  );

  cfgacc_rdport u_rdport (
    .clk      (clk),
    .rst      (rst),
    .rd_acc   (rd_acc),
    .rd_word  (rd_word),
    .fin_rd   (fin_rd),
    .fin_data (fin_data),
    .rvalid   (sw_rvalid),
    .rdata    (sw_rdata)
  );

endmodule

// File: rtl/cfgacc_chk.sv
module cfgacc_chk #(
  parameter int unsigned BUS_W = 8,
  parameter int unsigned DEV_W = 5,
  parameter int unsigned FN_W  = 3,
  parameter int unsigned REG_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             sw_busy,
  input logic             sw_rvalid,
  input logic [31:0]      sw_rdata,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic             req_type1,
  input logic [BUS_W-1:0] req_bus,
  input logic [DEV_W-1:0] req_dev,
  input logic [FN_W-1:0]  req_fn,
  input logic [REG_W-1:0] req_reg,
  input logic [31:0]      req_wdata,
  input logic             cpl_ur,
  input logic             fin,
  input logic             fin_rd,
  input logic             ctrl_en,
  input logic             ctrl_t1,
  input logic             err_ur,
  input logic [31:0]      addr_q
);

  // R1
  rst_idle_chk: assert property (@(posedge clk)
    rst |=> !req_valid && !sw_busy);

  // R4
  req_busy_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> sw_busy);

  // R4
  rvalid_free_chk: assert property (@(posedge clk) disable iff (rst)
    sw_rvalid |-> !sw_busy);

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_write)
      && $stable(req_type1) && $stable(req_bus) && $stable(req_dev)
      && $stable(req_fn) && $stable(req_reg) && $stable(req_wdata));

  // R7
  ur_ones_chk: assert property (@(posedge clk) disable iff (rst)
    fin_rd && cpl_ur |=> sw_rvalid && (sw_rdata == 32'hFFFF_FFFF));

  // R7
  ur_flag_chk: assert property (@(posedge clk) disable iff (rst)
    fin && cpl_ur |=> err_ur);

  // R9
  off_noreq_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_en && !sw_busy |=> !req_valid);

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    sw_busy |=> $stable(addr_q) && $stable(ctrl_en) && $stable(ctrl_t1));

endmodule

bind cfgacc cfgacc_chk #(
  .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .REG_W(REG_W)
) u_cfgacc_chk (
  .clk       (clk),
  .rst       (rst),
  .sw_busy   (sw_busy),
  .sw_rvalid (sw_rvalid),
  .sw_rdata  (sw_rdata),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_type1 (req_type1),
  .req_bus   (req_bus),
  .req_dev   (req_dev),
  .req_fn    (req_fn),
  .req_reg   (req_reg),
  .req_wdata (req_wdata),
  .cpl_ur    (cpl_ur),
  .fin       (fin),
  .fin_rd    (fin_rd),
  .ctrl_en   (ctrl_en),
  .ctrl_t1   (ctrl_t1),
  .err_ur    (err_ur),
  .addr_q    (addr_q)
);

// File: tb/cfgacc_bench.sv
`timescale 1ns/1ps
module cfgacc_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sw_en = 1'b0;
  logic        sw_we = 1'b0;
  logic [1:0]  sw_sel = 2'd0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] sw_rdata;
  logic        sw_rvalid;
  logic        sw_busy;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic        req_write;
  logic        req_type1;
  logic [7:0]  req_bus;
  logic [4:0]  req_dev;
  logic [2:0]  req_fn;
  logic [9:0]  req_reg;
  logic [31:0] req_wdata;
  logic        cpl_valid = 1'b0;
  logic        cpl_ur = 1'b0;
  logic [31:0] cpl_data = '0;

  always #4 clk = ~clk;

  cfgacc u_cfgacc (
    .clk(clk), .rst(rst), .sw_en(sw_en), .sw_we(sw_we), .sw_sel(sw_sel),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .sw_rvalid(sw_rvalid),
    .sw_busy(sw_busy), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_type1(req_type1), .req_bus(req_bus),
    .req_dev(req_dev), .req_fn(req_fn), .req_reg(req_reg),
    .req_wdata(req_wdata), .cpl_valid(cpl_valid), .cpl_ur(cpl_ur),
    .cpl_data(cpl_data)
  );

  int checks = 0;
  int fails  = 0;

  // completer stub state
  int          stub_gap = 0;
  int          stub_lat = 1;
  int          req_count = 0;
  logic        cap_write;
  logic        cap_t1;
  logic [7:0]  cap_bus;
  logic [4:0]  cap_dev;
  logic [2:0]  cap_fn;
  logic [9:0]  cap_reg;
  logic [31:0] cap_wdata;

  function automatic logic [31:0] model(input logic [7:0] b, input logic [4:0] d,
                                        input logic [2:0] f, input logic [9:0] r,
                                        input logic t);
    return {b, d, f, (t ? 6'h2A : 6'h15), r};
  endfunction

  function automatic logic is_ur(input logic [4:0] d);
    return d >= 5'd24;
  endfunction

  // completer: accept after stub_gap cycles, complete stub_lat cycles later
  initial begin
    forever begin
      @(negedge clk);
      if (req_valid && !rst) begin
        repeat (stub_gap) @(negedge clk);
        req_ready = 1'b1;
        cap_write = req_write; cap_t1 = req_type1; cap_bus = req_bus;
        cap_dev = req_dev; cap_fn = req_fn; cap_reg = req_reg;
        cap_wdata = req_wdata;
        req_count++;
        @(negedge clk);
        req_ready = 1'b0;
        repeat (stub_lat - 1) @(negedge clk);
        cpl_valid = 1'b1;
        cpl_ur    = is_ur(cap_dev);
        cpl_data  = model(cap_bus, cap_dev, cap_fn, cap_reg, cap_t1);
        @(negedge clk);
        cpl_valid = 1'b0;
        cpl_ur    = 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] s, input logic [31:0] d);
    sw_en = 1'b1; sw_we = 1'b1; sw_sel = s; sw_wdata = d;
    @(negedge clk);
    sw_en = 1'b0; sw_we = 1'b0;
  endtask

  task automatic reg_rd(input string tag, input logic [1:0] s, input logic [31:0] exp);
    sw_en = 1'b1; sw_we = 1'b0; sw_sel = s;
    @(negedge clk);
    sw_en = 1'b0;
    chk({tag, " rvalid (R11)"}, {31'b0, sw_rvalid}, 32'd1);
    chk(tag, sw_rdata, exp);
  endtask

  task automatic cfg_rd(output logic [31:0] d);
    sw_en = 1'b1; sw_we = 1'b0; sw_sel = 2'd2;
    @(negedge clk);
    sw_en = 1'b0;
    chk("R4 busy after launch", {31'b0, sw_busy}, 32'd1);
    for (int i = 0; i < 300 && !sw_rvalid; i++) @(negedge clk);
    chk("R4 busy low with result", {31'b0, sw_busy}, 32'd0);
    d = sw_rdata;
  endtask

  task automatic cfg_wr(input logic [31:0] d);
    sw_en = 1'b1; sw_we = 1'b1; sw_sel = 2'd2; sw_wdata = d;
    @(negedge clk);
    sw_en = 1'b0; sw_we = 1'b0;
    chk("R5 busy after launch", {31'b0, sw_busy}, 32'd1);
    for (int i = 0; i < 300 && sw_busy; i++) @(negedge clk);
  endtask

  task automatic ur_clear(input string tag);
    reg_rd({tag, " R7 error set"}, 2'd3, 32'h10);
    reg_wr(2'd3, 32'hFFFF_FFEF);
    reg_rd({tag, " R8 bit4 zero keeps flag"}, 2'd3, 32'h10);
    reg_wr(2'd3, 32'h0000_0010);
    reg_rd({tag, " R8 bit4 one clears"}, 2'd3, 32'h0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] keep;
    int n0;
    keep = (32'hFFFF_FFFF << 16) | (((32'd1 << 10) - 1) << 2);

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'b0, sw_busy}, 32'd0);
    chk("R1 req_valid", {31'b0, req_valid}, 32'd0);
    reg_rd("R1 target", 2'd0, 32'h0);
    reg_rd("R1 control", 2'd1, 32'h0);
    reg_rd("R1 data", 2'd2, 32'h0);
    reg_rd("R1 error", 2'd3, 32'h0);

    // R2 / R3 stored bit masks
    reg_wr(2'd0, 32'hFFFF_FFFF);
    reg_rd("R2 target mask", 2'd0, keep);
    reg_wr(2'd1, 32'hFFFF_FFFF);
    reg_rd("R3 control mask", 2'd1, 32'h8000_0100);

    // R9 disabled data register is local storage
    reg_wr(2'd1, 32'h0);
    n0 = req_count;
    reg_wr(2'd2, 32'h1234_5678);
    reg_rd("R9 local data", 2'd2, 32'h1234_5678);
    chk("R9 no request", n0, req_count);

    // sweep of type, target and timing
    for (int t = 0; t < 2; t++) begin
      for (int di = 0; di < 4; di++) begin
        logic [7:0]  b;
        logic [4:0]  dv;
        logic [2:0]  f;
        logic [9:0]  r;
        logic [31:0] wd;
        logic        ur;
        b  = 8'(8'h21 * (di + 1) + t);
        dv = (di == 0) ? 5'd0 : (di == 1) ? 5'd7 : (di == 2) ? 5'd19 : 5'd28;
        f  = 3'(di * 3 + t);
        r  = 10'(di * 93 + t * 11 + 1);
        wd = 32'hC0DE_0000 + 32'(di * 16 + t);
        ur = is_ur(dv);
        stub_gap = di;
        stub_lat = 1 + di + t;
        reg_wr(2'd0, {b, dv, f, 4'h0, r, 2'b11});
        reg_wr(2'd1, 32'h8000_0000 | (32'(t) << 8));
        n0 = req_count;
        cfg_rd(d);
        chk("R4 one request", req_count, n0 + 1);
        chk("R4 read data / R7 ones", d, ur ? 32'hFFFF_FFFF : model(b, dv, f, r, t[0]));
        chk("R2 request fields", {cap_bus, cap_dev, cap_fn, 6'b0, cap_reg},
            {b, dv, f, 6'b0, r});
        chk("R4 type and read", {30'b0, cap_t1, cap_write}, {30'b0, t[0], 1'b0});
        if (ur) ur_clear("rd");
        else reg_rd("R7 no error", 2'd3, 32'h0);
        cfg_wr(wd);
        chk("R5 write request", {31'b0, cap_write}, 32'd1);
        chk("R5 write data", cap_wdata, wd);
        chk("R6 write fields", {cap_bus, cap_dev, cap_fn, 6'b0, cap_reg},
            {b, dv, f, 6'b0, r});
        if (ur) ur_clear("wr");
        reg_wr(2'd1, 32'h0);
        n0 = req_count;
        reg_rd("R9 data after disable", 2'd2, wd);
        chk("R9 no request after disable", n0, req_count);
      end
    end

    // R10 accesses while busy are ignored
    stub_gap = 0;
    stub_lat = 8;
    reg_wr(2'd0, 32'h0108_0044);
    reg_wr(2'd1, 32'h8000_0000);
    sw_en = 1'b1; sw_we = 1'b0; sw_sel = 2'd2;
    @(negedge clk);
    sw_en = 1'b1; sw_we = 1'b1; sw_sel = 2'd0; sw_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    sw_sel = 2'd1; sw_wdata = 32'h0;
    @(negedge clk);
    sw_we = 1'b0; sw_sel = 2'd0;
    @(negedge clk);
    sw_en = 1'b0;
    chk("R10 busy read ignored", {31'b0, sw_rvalid}, 32'd0);
    for (int i = 0; i < 300 && !sw_rvalid; i++) @(negedge clk);
    chk("R10 result still returned", sw_rdata, model(8'h01, 5'd1, 3'd0, 10'h11, 1'b0));
    reg_rd("R10 target unchanged", 2'd0, 32'h0108_0044);
    reg_rd("R10 control unchanged", 2'd1, 32'h8000_0000);

    finish_run();
  end

endmodule